// File: doc/BRIEF.md
# Cascadable 32-Line Interrupt Controller

This block collects 32 external interrupt request lines and turns them into two processor-facing outputs: a normal interrupt and a critical interrupt. Every line passes through a two-flop synchronizer. Each line is then qualified by two per-source configuration bits. The trigger bit chooses edge or level sensing. The polarity bit chooses rising or active-high against falling or active-low.

A qualified event is latched into a per-source status bit. The status bit is latched whether or not the source is enabled. Software clears status bits by writing ones to them. An enable register gates status into a masked pending view. A routing register sends each pending source to either the normal output or the critical output. A vector register returns the number of the highest-priority pending source.

Either output may feed an input line of a second controller, which builds a cascade.

Top module: `irqc_top`

## Requirements
- R1: After reset, the following hold. Status, enable, routing and trigger read 0. Polarity reads all ones. Pending reads 0. Vector reads 32'hFFFF_FFFF. Both interrupt outputs are low.
- R2: Source n uses bit (31 − n) of every per-source register. The word addresses are:
  - 0x0: status. Writing 1 to a bit clears it.
  - 0x2: enable.
  - 0x3: routing.
  - 0x4: polarity.
  - 0x5: trigger.
  - 0x6: pending (read-only).
  - 0x7: vector (read-only).
  Every other address reads 0. Read data appears on the cycle after the read strobe and holds until the next read.
- R3: A level source has trigger bit 0. Polarity 1 means active-high and polarity 0 means active-low. Its status bit is set on every cycle its synchronized line is active, three clock edges after the pin changes. A status bit never sets without a qualifying event.
- R4: An edge source has trigger bit 1. Polarity 1 selects the rising edge and polarity 0 selects the falling edge. It sets its status bit once per qualifying transition. The opposite transition does not set it. A cleared bit stays clear while the line is held.
- R5: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. Writing all ones clears every source that does not raise a new event in that cycle.
- R6: Clearing a level source has no effect while its line is still active. This holds even when the source is disabled.
- R7: Status bits latch regardless of the enable register. A masked event shows up in pending once it is enabled.
- R8: Pending reads as status AND enable.
- R9: The normal output is the OR of the pending bits whose routing bit is 0. The critical output is the OR of the pending bits whose routing bit is 1.
- R10: The vector reads the number of the pending source with the lowest bit position, which is the highest source number. It reads all ones when nothing is pending.
- R11: If a new event and a clearing write hit the same status bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| irq_src_i | input | 32 | Asynchronous request lines; bit 31 − n is source n |
| bus_addr_i | input | 4 | Register word address |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, one cycle after the read strobe |
| irq_nc_o | output | 1 | Normal interrupt output |
| irq_cr_o | output | 1 | Critical interrupt output |

## Verification
The two functions that can coincide are a software clear of a status bit and a fresh event on that same bit. An edge source's status is first set and its line lowered. The line is then raised again, and a write of 1 to that status bit is timed so that it takes effect on exactly the clock edge that latches the new rising edge. A read-back must still show the bit set. The same clear-against-set rule is also exercised by a held level line, which a clear must not remove.

// File: rtl/irqc_pkg.sv
`timescale 1ns/1ps
package irqc_pkg;

  // Word addresses of the register port
  typedef enum logic [3:0] {
    A_STAT = 4'h0,
    A_ENAB = 4'h2,
    A_CRIT = 4'h3,
    A_POL  = 4'h4,
    A_TRIG = 4'h5,
    A_PEND = 4'h6,
    A_VEC  = 4'h7
  } reg_addr_e;

  // Qualify one synchronized line: cur is the current sample, prv the one before.
  function automatic logic sense_hit(logic trig, logic pol, logic cur, logic prv);
    if (trig) return pol ? (cur & ~prv) : (~cur & prv);
    return pol ? cur : ~cur;
  endfunction

endpackage

// File: rtl/irqc_sync.sv
`timescale 1ns/1ps
module irqc_sync import irqc_pkg::*; #(
  parameter int N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] raw_i,
  input  logic [N-1:0] trig_i,
  input  logic [N-1:0] pol_i,
  output logic [N-1:0] hit_o
);
  logic [N-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= raw_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_line
    assign hit_o[i] = sense_hit(trig_i[i], pol_i[i], s2_q[i], s3_q[i]);
  end

  // An edge source with steady configuration never qualifies two cycles in a row
  AST_EDGE_ONESHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o & $past(hit_o) & trig_i & $past(trig_i) & ~(pol_i ^ $past(pol_i))) == '0); // R4

endmodule

// File: rtl/irqc_status.sv
`timescale 1ns/1ps
module irqc_status #(
  parameter int N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] stat_o
);
  logic [N-1:0] stat_q;

  // New events dominate clears so none is lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= (stat_q & ~clr_i) | set_i;
  end

  assign stat_o = stat_q;

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((stat_o & $past(set_i)) == $past(set_i))); // R11

  AST_CLR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_i & ~set_i) != '0) |=> ((stat_o & $past(clr_i & ~set_i)) == '0)); // R5

  AST_NO_SPONT_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((stat_o & ~$past(stat_o) & ~$past(set_i)) == '0)); // R3

endmodule

// File: rtl/irqc_prio.sv
`timescale 1ns/1ps
module irqc_prio #(
  parameter int N = 32
) (
  input  logic [N-1:0] pend_i,
  output logic [N-1:0] vec_o
);
  localparam int IW = $clog2(N);

  logic [IW-1:0] win_idx;
  logic          found;

  // Lowest set bit position wins; walk from the top down so the last hit stays
  always_comb begin
    win_idx = '0;
    found   = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_i[i]) begin
        win_idx = IW'(i);
        found   = 1'b1;
      end
    end
  end

  assign vec_o = found ? (N'(N - 1) - N'(win_idx)) : '1;

  always_comb begin
    if (found) begin
      AST_VEC_LOWEST: assert ((pend_i & ((N'(1) << win_idx) - N'(1))) == '0); // R10
    end
  end

endmodule

// File: rtl/irqc_top.sv
`timescale 1ns/1ps
module irqc_top import irqc_pkg::*; #(
  parameter int N  = 32,
  parameter int AW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  irq_src_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic          bus_wr_i,
  input  logic          bus_rd_i,
  input  logic [N-1:0]  bus_wdata_i,
  output logic [N-1:0]  bus_rdata_o,
  output logic          irq_nc_o,
  output logic          irq_cr_o
);
  logic [N-1:0] enab_q, crit_q, pol_q, trig_q;
  logic [N-1:0] hit_w, clr_w, stat_w, pend_w, vec_w;
  logic [N-1:0] rd_mux, rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      enab_q <= '0;
      crit_q <= '0;
      pol_q  <= '1;
      trig_q <= '0;
    end else if (bus_wr_i) begin
      if (bus_addr_i == AW'(A_ENAB)) enab_q <= bus_wdata_i;
      if (bus_addr_i == AW'(A_CRIT)) crit_q <= bus_wdata_i;
      if (bus_addr_i == AW'(A_POL))  pol_q  <= bus_wdata_i;
      if (bus_addr_i == AW'(A_TRIG)) trig_q <= bus_wdata_i;
    end
  end

  assign clr_w = (bus_wr_i && bus_addr_i == AW'(A_STAT)) ? bus_wdata_i : '0;

  irqc_sync #(.N(N)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .raw_i  (irq_src_i),
    .trig_i (trig_q),
    .pol_i  (pol_q),
    .hit_o  (hit_w)
  );

  irqc_status #(.N(N)) u_status (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (hit_w),
    .clr_i  (clr_w),
    .stat_o (stat_w)
  );

  assign pend_w = stat_w & enab_q;

  irqc_prio #(.N(N)) u_prio (
    .pend_i (pend_w),
    .vec_o  (vec_w)
  );

  assign irq_nc_o = |(pend_w & ~crit_q);
  assign irq_cr_o = |(pend_w & crit_q);

  always_comb begin
    rd_mux = '0;
    if (bus_addr_i == AW'(A_STAT)) rd_mux = stat_w;
    if (bus_addr_i == AW'(A_ENAB)) rd_mux = enab_q;
    if (bus_addr_i == AW'(A_CRIT)) rd_mux = crit_q;
    if (bus_addr_i == AW'(A_POL))  rd_mux = pol_q;
    if (bus_addr_i == AW'(A_TRIG)) rd_mux = trig_q;
    if (bus_addr_i == AW'(A_PEND)) rd_mux = pend_w;
    if (bus_addr_i == AW'(A_VEC))  rd_mux = vec_w;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rdata_q <= '0;
    else if (bus_rd_i) rdata_q <= rd_mux;
  end

  assign bus_rdata_o = rdata_q;

  AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_rd_i |=> $stable(bus_rdata_o)); // R2

  AST_OUT_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_nc_o | irq_cr_o) == (vec_w != '1)); // R9

  AST_LVL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((hit_w & ~trig_q) != '0) |=> ((stat_w & $past(hit_w & ~trig_q)) == $past(hit_w & ~trig_q))); // R6

endmodule

// File: tb/irqc_top_bench.sv
`timescale 1ns/1ps
module irqc_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0;
  logic [3:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic        rd = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_nc, irq_cr;
  logic        rd_seen = 1'b0;

  int checks = 0;
  int fails  = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  irqc_top u_irqc_top (
    .clk_i (clk), .rst_ni (rst_n), .irq_src_i (src),
    .bus_addr_i (addr), .bus_wr_i (wr_en), .bus_rd_i (rd),
    .bus_wdata_i (wdata), .bus_rdata_o (rdata),
    .irq_nc_o (irq_nc), .irq_cr_o (irq_cr)
  );

  always @(posedge clk) rd_seen <= rd;

  // Monitor: read data is due the cycle after the strobe (R2)
  always @(negedge clk) begin
    logic [31:0] e;
    string t;
    if (rd_seen && exp_q.size() > 0) begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rdata !== e) begin
        fails++;
        $display("FAIL %s actual=%h expected=%h", t, rdata, e);
      end
    end
  end

  task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [3:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic pin_chk(input logic act, input logic e, input string t);
    checks++;
    if (act !== e) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", t, act, e);
    end
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    checks++; fails++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    bus_rd(4'h0, 32'h0, "R1 status");
    bus_rd(4'h2, 32'h0, "R1 enable");
    bus_rd(4'h3, 32'h0, "R1 routing");
    bus_rd(4'h5, 32'h0, "R1 trigger");
    bus_rd(4'h4, 32'hFFFF_FFFF, "R1 polarity");
    bus_rd(4'h6, 32'h0, "R1 pending");
    bus_rd(4'h7, 32'hFFFF_FFFF, "R1 vector");
    pin_chk(irq_nc, 1'b0, "R1 normal out");
    pin_chk(irq_cr, 1'b0, "R1 critical out");
    bus_rd(4'h1, 32'h0, "R2 unmapped 0x1");
    bus_rd(4'h8, 32'h0, "R2 unmapped 0x8");

    // Level-high source 3 (bit 28), masked
    src[28] = 1'b1; settle();
    bus_rd(4'h0, 32'h1000_0000, "R3 R7 level latched while masked");
    bus_rd(4'h6, 32'h0, "R8 pending masked");
    pin_chk(irq_nc, 1'b0, "R9 masked no output");
    bus_wr(4'h2, 32'h1000_0000);
    bus_rd(4'h6, 32'h1000_0000, "R7 R8 pending after enable");
    pin_chk(irq_nc, 1'b1, "R9 normal out");
    bus_rd(4'h7, 32'd3, "R10 vector source 3");
    bus_wr(4'h0, 32'h1000_0000);
    bus_rd(4'h0, 32'h1000_0000, "R6 clear while active");
    bus_wr(4'h2, 32'h0);
    bus_wr(4'h0, 32'h1000_0000);
    bus_rd(4'h0, 32'h1000_0000, "R6 clear while active and disabled");
    bus_wr(4'h2, 32'h1000_0000);
    src[28] = 1'b0; settle();
    bus_wr(4'h0, 32'h0);
    bus_rd(4'h0, 32'h1000_0000, "R5 write zero keeps");
    bus_wr(4'h0, 32'h1000_0000);
    bus_rd(4'h0, 32'h0, "R5 write one clears");
    pin_chk(irq_nc, 1'b0, "R9 normal out drops");

    // Rising-edge source 0 (bit 31), critical
    bus_wr(4'h5, 32'h8000_0000);
    bus_wr(4'h3, 32'h8000_0000);
    bus_wr(4'h2, 32'h9000_0000);
    src[31] = 1'b1; settle();
    bus_rd(4'h0, 32'h8000_0000, "R4 rising edge latched");
    pin_chk(irq_cr, 1'b1, "R9 critical out");
    pin_chk(irq_nc, 1'b0, "R9 normal out quiet");
    bus_wr(4'h0, 32'h8000_0000); settle();
    bus_rd(4'h0, 32'h0, "R4 held line no relatch");
    pin_chk(irq_cr, 1'b0, "R9 critical out drops");

    // Falling-edge source 10 (bit 21)
    bus_wr(4'h5, 32'h8020_0000);
    bus_wr(4'h4, 32'hFFDF_FFFF);
    src[21] = 1'b1; settle();
    bus_rd(4'h0, 32'h0, "R4 rising ignored on falling source");
    src[21] = 1'b0; settle();
    bus_rd(4'h0, 32'h0020_0000, "R4 falling edge latched");

    // Priority: sources 3 and 10 pending
    bus_wr(4'h2, 32'h9020_0000);
    src[28] = 1'b1; settle();
    bus_rd(4'h0, 32'h1020_0000, "R3 two sources");
    bus_rd(4'h7, 32'd10, "R10 higher source number wins");

    // Collision on source 0: bit set, then clear meets a new edge
    src[31] = 1'b0; settle();
    src[31] = 1'b1; settle();
    src[31] = 1'b0; settle();
    bus_rd(4'h0, 32'h9020_0000, "R4 source 0 set before collision");
    src[31] = 1'b1;
    repeat (2) @(negedge clk);
    bus_wr(4'h0, 32'h8000_0000);
    bus_rd(4'h0, 32'h9020_0000, "R11 new edge beats clear");

    // Clear all with a held level line
    bus_wr(4'h0, 32'hFFFF_FFFF);
    bus_rd(4'h0, 32'h1000_0000, "R5 R6 clear all keeps active level");
    bus_rd(4'h7, 32'd3, "R10 vector after clear all");
    src[28] = 1'b0; settle();
    bus_wr(4'h0, 32'hFFFF_FFFF);
    bus_rd(4'h7, 32'hFFFF_FFFF, "R10 vector none pending");
    bus_rd(4'h6, 32'h0, "R8 pending empty");

    // Active-low level source 26 (bit 5)
    bus_wr(4'h4, 32'hFFDF_FFDF); settle();
    bus_rd(4'h0, 32'h0000_0020, "R3 active-low level");
    src[5] = 1'b1; settle();
    bus_wr(4'h0, 32'h0000_0020);
    bus_rd(4'h0, 32'h0, "R3 active-low released and cleared");

    repeat (2) @(negedge clk);
    report();
  end
endmodule